// File: doc/BRIEF.md
# Interleaved Memory Bank Scheduler

This block accepts a stream of word addresses from one requester and sends each access to one of several memory banks. Each bank takes its own address, so the stream need not be contiguous. The bank is picked from the low bits of the word address, and the rest of the address becomes the row inside that bank. After a bank accepts an access, it stays occupied for a fixed number of clock cycles. With a memory cycle of about 15 ns and a processor cycle of about 2.167 ns, that busy time rounds up to 7 cycles.

The requester holds a valid request until the scheduler accepts it. If the addressed bank is still occupied, the scheduler holds the request back. Requests are taken strictly in the order they arrive, so one held request also blocks every request behind it. A running count of held-back cycles lets a designer measure how much a given access pattern costs. For a fixed stride, the same bank comes around again every `BANK_CNT / gcd(stride, BANK_CNT)` accesses. The stream stalls only when that interval is shorter than the busy time.

Top module: `ilv_bank_sched`

## Requirements
- R1: The bank of an access is `req_addr[log2(BANK_CNT)-1:0]` and its row is `req_addr >> log2(BANK_CNT)`. On the clock edge that accepts a request, `issue_valid` goes high for the next cycle, with that bank on `issue_bank` and that row on `issue_row`.
- R2: Suppose an access to bank b is accepted at edge e. No further access to bank b is accepted before edge e + BUSY_CYC.
- R3: `req_ready` is high in the same cycle whenever the addressed bank is free. A valid request to a free bank is therefore accepted at the next edge, with no added delay.
- R4: Accesses leave in the order they were presented. `issue_valid` is high in a cycle exactly when a request was accepted at the edge before it. A stalled request holds back all later requests.
- R5: `stall_cnt` rises by exactly one for each cycle in which `req_valid` is high and `req_ready` is low. In every other cycle it keeps its value.
- R6: A cycle with `req_valid` low neither occupies a bank nor counts as a stall, whatever `req_addr` carries.
- R7: After reset, every bank is free, `stall_cnt` is zero and `issue_valid` is low.
- R8: A fixed-stride stream whose bank revisit interval, `BANK_CNT / gcd(stride, BANK_CNT)`, is at least BUSY_CYC never stalls. With 8 banks and a busy time of 7, this holds for every odd stride.
- R9: A bank's busy time runs down whether or not requests are present. After an idle stretch, a bank accepts again exactly BUSY_CYC cycles after its last access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present on `req_addr` |
| req_addr | input | ADDR_W | Word address of the request. The requester holds it while `req_ready` is low |
| req_ready | output | 1 | The addressed bank is free, so the request is taken at this edge |
| issue_valid | output | 1 | An access left for a bank at the previous edge |
| issue_bank | output | log2(BANK_CNT) | Bank of the access that left |
| issue_row | output | ADDR_W - log2(BANK_CNT) | Row within that bank |
| stall_cnt | output | STALL_W | Number of cycles a valid request has been held back |

## Verification
The hardest case to reach from the ports is a bank that frees up at exactly the cycle a request comes back to it. Reaching it means back-to-back accesses plus a stride chosen to land on the same bank after a known number of steps. The bench sweeps every stride from 0 to 16, plus a scrambled gather-like pattern, over eight banks. For each access it works out the exact cycle of acceptance as the later of two times: one cycle after the previous acceptance, and the busy time after the last access to the same bank. It then checks `req_ready` in every single cycle. A separate sequence sends one access, leaves the bus idle with the same bank's address present, and returns at exactly the freeing cycle.

// File: rtl/ilv_pkg.sv
// Package: shared defaults and helpers for the interleaved bank scheduler.
// Assumes the bank count is a power of two and the busy time is at least 1.
package ilv_pkg;

    localparam int DEF_ADDR_W   = 16;
    localparam int DEF_BANK_CNT = 8;
    localparam int DEF_BUSY_CYC = 7;
    localparam int DEF_STALL_W  = 32;

    // Value loaded into a bank timer so the bank frees busy cycles later.
    function automatic int timer_load(input int busy);
        return (busy > 0) ? busy - 1 : 0;
    endfunction

    // Width of a counter that must hold values up to max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/ilv_bank_timer.sv
// Module: per-bank busy countdown.
// On load it takes the value LOAD and then counts down once per cycle.
// The bank is busy while the count is non-zero.
// Assumes load is only raised while the bank is free.
module ilv_bank_timer #(
    parameter int CNT_W = 3,
    parameter int LOAD  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Load on accept, otherwise run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(LOAD);
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ilv_stall_counter.sv
// Module: counts cycles in which a valid request is held back.
// Wraps at 2**W. Assumes inc is already qualified by valid and not ready.
module ilv_stall_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Step the count by one on each held-back cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ilv_issue_reg.sv
// Module: registers the bank and row of each accepted access toward the banks.
// Assumes fire is high only at the edge that accepts a request.
module ilv_issue_reg #(
    parameter int BANK_W = 3,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ROW_W-1:0]  row_in,
    output logic              issue_valid,
    output logic [BANK_W-1:0] issue_bank,
    output logic [ROW_W-1:0]  issue_row
);

    // Valid flag follows every edge; a new access produces a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
        end else begin
            issue_valid <= fire;
        end
    end

    // Capture the bank and row only when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_bank <= '0;
            issue_row  <= '0;
        end else if (fire) begin
            issue_bank <= bank_in;
            issue_row  <= row_in;
        end
    end

endmodule

// File: rtl/ilv_bank_sched.sv
// Module: top of the interleaved bank scheduler.
// Picks a bank from the low address bits and accepts the request only when
// that bank's timer has expired. It issues in strict order and counts stall cycles.
// Assumes BANK_CNT is a power of two, at least 2, and that the requester holds
// req_addr stable while req_valid is high and req_ready is low.
module ilv_bank_sched #(
    parameter int ADDR_W   = ilv_pkg::DEF_ADDR_W,
    parameter int BANK_CNT = ilv_pkg::DEF_BANK_CNT,
    parameter int BUSY_CYC = ilv_pkg::DEF_BUSY_CYC,
    parameter int STALL_W  = ilv_pkg::DEF_STALL_W,
    localparam int BANK_W  = $clog2(BANK_CNT),
    localparam int ROW_W   = ADDR_W - BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               issue_valid,
    output logic [BANK_W-1:0]  issue_bank,
    output logic [ROW_W-1:0]   issue_row,
    output logic [STALL_W-1:0] stall_cnt
);

    localparam int TMR_LOAD = ilv_pkg::timer_load(BUSY_CYC);
    localparam int TMR_W    = ilv_pkg::cnt_width(TMR_LOAD);

    logic [BANK_W-1:0]   bank_sel;
    logic [ROW_W-1:0]    row_sel;
    logic [BANK_CNT-1:0] bank_busy;
    logic                fire;
    logic                held;

    // Split the word address into bank index and row.
    assign bank_sel = req_addr[BANK_W-1:0];
    assign row_sel  = req_addr[ADDR_W-1:BANK_W];

    // Accept when the addressed bank is free.
    assign req_ready = !bank_busy[bank_sel];
    assign fire      = req_valid && req_ready;
    assign held      = req_valid && !req_ready;

    // One busy timer per bank, loaded when that bank accepts.
    for (genvar gi = 0; gi < BANK_CNT; gi++) begin : g_bank
        logic hit;
        assign hit = fire && (bank_sel == BANK_W'(gi));
        ilv_bank_timer #(
            .CNT_W (TMR_W),
            .LOAD  (TMR_LOAD)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (hit),
            .busy  (bank_busy[gi])
        );
    end

    ilv_issue_reg #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .bank_in     (bank_sel),
        .row_in      (row_sel),
        .issue_valid (issue_valid),
        .issue_bank  (issue_bank),
        .issue_row   (issue_row)
    );

    ilv_stall_counter #(
        .W (STALL_W)
    ) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (held),
        .count (stall_cnt)
    );

endmodule

// File: rtl/ilv_bank_sched_chk.sv
// Module: checker bound to the scheduler.
// It keeps its own per-bank count of cycles since each bank's last access,
// and uses it to judge the busy-window and free-bank rules from the ports.
module ilv_bank_sched_chk #(
    parameter int ADDR_W   = 16,
    parameter int BANK_CNT = 8,
    parameter int BUSY_CYC = 7,
    parameter int STALL_W  = 32,
    localparam int BANK_W  = $clog2(BANK_CNT),
    localparam int ROW_W   = ADDR_W - BANK_W,
    localparam int SW      = ilv_pkg::cnt_width(BUSY_CYC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_ready,
    input logic               issue_valid,
    input logic [BANK_W-1:0]  issue_bank,
    input logic [ROW_W-1:0]   issue_row,
    input logic [STALL_W-1:0] stall_cnt
);

    logic [SW-1:0]     since_q [BANK_CNT];
    logic [BANK_W-1:0] bsel;
    logic              acc;
    logic              gap_ok;

    assign bsel   = req_addr[BANK_W-1:0];
    assign acc    = req_valid && req_ready;
    assign gap_ok = (32'(since_q[bsel]) >= BUSY_CYC - 1);

    // Track, per bank, how many edges have passed since its last access.
    always_ff @(posedge clk) begin
        for (int i = 0; i < BANK_CNT; i++) begin
            if (!rst_n) begin
                since_q[i] <= SW'(BUSY_CYC);
            end else if (acc && (bsel == BANK_W'(i))) begin
                since_q[i] <= '0;
            end else if (32'(since_q[i]) < BUSY_CYC) begin
                since_q[i] <= since_q[i] + 1'b1;
            end
        end
    end

    assert_bank_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> gap_ok);

    assert_free_bank_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && gap_ok) |-> req_ready);

    assert_issue_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> issue_valid);

    assert_no_spurious_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !issue_valid);

    assert_issue_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (issue_bank == $past(req_addr[BANK_W-1:0])));

    assert_issue_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (issue_row == $past(req_addr[ADDR_W-1:BANK_W])));

    assert_stall_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (stall_cnt == $past(stall_cnt) + STALL_W'(1)));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_ready) |=> $stable(stall_cnt));

endmodule

bind ilv_bank_sched ilv_bank_sched_chk #(
    .ADDR_W   (ADDR_W),
    .BANK_CNT (BANK_CNT),
    .BUSY_CYC (BUSY_CYC),
    .STALL_W  (STALL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .issue_valid (issue_valid),
    .issue_bank  (issue_bank),
    .issue_row   (issue_row),
    .stall_cnt   (stall_cnt)
);

// File: tb/ilv_bank_sched_tb.sv
// Bench: sweeps strides and a scrambled pattern over 8 banks with busy time 7,
// predicting the exact acceptance cycle of every access arithmetically.
module ilv_bank_sched_tb;

    localparam int ADDR_W = 16;
    localparam int BANKS  = 8;
    localparam int BUSY   = 7;
    localparam int BW     = 3;
    localparam int NACC   = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready;
    logic              issue_valid;
    logic [BW-1:0]     issue_bank;
    logic [ADDR_W-BW-1:0] issue_row;
    logic [31:0]       stall_cnt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    ilv_bank_sched u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ready   (req_ready),
        .issue_valid (issue_valid),
        .issue_bank  (issue_bank),
        .issue_row   (issue_row),
        .stall_cnt   (stall_cnt)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    function automatic int gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Drive one stream with valid held high and check acceptance cycle by cycle.
    task automatic run_stream(input int stride, input bit scramble);
        logic [ADDR_W-1:0] addrs [NACC];
        int expc [NACC];
        int last [BANKS];
        int k = 0;
        int c = 0;
        int s0;
        bit pf = 1'b0;
        logic [ADDR_W-1:0] pa = '0;
        int seed = 17;
        for (int b = 0; b < BANKS; b++) last[b] = -1000;
        for (int i = 0; i < NACC; i++) begin
            if (scramble) begin
                seed = (seed * 5 + 3) % 65536;
                addrs[i] = ADDR_W'(seed);
            end else begin
                addrs[i] = ADDR_W'(100 + i * stride);
            end
            begin
                int bk = int'(addrs[i]) % BANKS;
                int t  = (i == 0) ? 0 : expc[i-1] + 1;
                if (last[bk] + BUSY > t) t = last[bk] + BUSY;
                expc[i]  = t;
                last[bk] = t;
            end
        end
        s0 = int'(stall_cnt);
        while (k < NACC) begin
            @(negedge clk);
            if (pf) begin
                check(issue_valid == 1'b1, "R4 issue pulse", int'(issue_valid), 1);
                check(issue_bank == pa[BW-1:0], "R1 bank", int'(issue_bank), int'(pa[BW-1:0]));
                check(issue_row == pa[ADDR_W-1:BW], "R1 row", int'(issue_row), int'(pa[ADDR_W-1:BW]));
            end else begin
                check(issue_valid == 1'b0, "R4 no issue", int'(issue_valid), 0);
            end
            req_valid = 1'b1;
            req_addr  = addrs[k];
            #1;
            check(req_ready == (c == expc[k]), (c == expc[k]) ? "R3 ready" : "R2 stall",
                  int'(req_ready), int'(c == expc[k]));
            pf = req_ready;
            pa = addrs[k];
            if (req_ready) k++;
            c++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(issue_valid == 1'b1 && issue_bank == pa[BW-1:0], "R1 last bank",
              int'(issue_bank), int'(pa[BW-1:0]));
        check(int'(stall_cnt) - s0 == expc[NACC-1] - (NACC - 1), "R5 stall count",
              int'(stall_cnt) - s0, expc[NACC-1] - (NACC - 1));
        if (!scramble && (BANKS / gcd(stride, BANKS)) >= BUSY)
            check(int'(stall_cnt) == s0, "R8 conflict-free stride", int'(stall_cnt) - s0, 0);
        repeat (BUSY + 2) @(negedge clk);
    endtask

    initial begin
        int s1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state.
        check(issue_valid == 1'b0, "R7 issue_valid", int'(issue_valid), 0);
        check(stall_cnt == 0, "R7 stall_cnt", int'(stall_cnt), 0);
        for (int a = 0; a < BANKS; a++) begin
            req_addr = ADDR_W'(a);
            #1;
            check(req_ready == 1'b1, "R7 bank free", int'(req_ready), 1);
        end

        // R6 and R9: a single access, then idle cycles while the same bank is addressed.
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 16'd3;
        #1;
        check(req_ready == 1'b1, "R3 first access", int'(req_ready), 1);
        s1 = int'(stall_cnt);
        for (int j = 1; j < BUSY; j++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_addr  = 16'd11;
            #1;
            check(req_ready == 1'b0, "R9 bank still busy", int'(req_ready), 0);
            check(int'(stall_cnt) == s1, "R6 idle not counted", int'(stall_cnt), s1);
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 16'd11;
        #1;
        check(req_ready == 1'b1, "R9 freed after idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(issue_valid && issue_bank == 3'd3 && issue_row == 13'd1, "R1 row after idle",
              int'(issue_row), 1);
        check(int'(stall_cnt) == s1, "R6 no stall counted", int'(stall_cnt), s1);
        repeat (BUSY + 2) @(negedge clk);

        // R2, R3, R4, R5, R8: stride sweep and a scrambled gather-like pattern.
        for (int s = 0; s <= 16; s++) run_stream(s, 1'b0);
        run_stream(0, 1'b1);

        summary();
    end

endmodule